// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block sits between a set of interrupt channels and a processor core. It latches requests from every channel, plus a non-maskable input and a hard-fault input. Each channel has its own programmable priority and enable bit. A runtime grouping field splits every 4-bit priority into two parts. The upper part is a preemption level. The lower part is a sub-priority, which only orders requests that are waiting. Software programs the priorities, the grouping field, the enables and two global mask bits through a word-addressed register port.

The block keeps a stack of the preemption levels of the handlers that are running. Each cycle it works out the execution priority from the top of that stack and from the mask bits. It then presents the most urgent waiting source to the core, but only if that source is strictly more urgent than the execution priority. The core accepts the offered source with an acknowledge. That pushes the source's level onto the stack and clears its pending flag. A one-cycle end-of-handler pulse pops the stack and restores the previous execution priority.

Top module: `irq_nest_arb`

## Requirements
- R1: Each channel priority is a byte of which only the upper 4 bits are stored. The lower 4 bits always read as zero, and values written to them are discarded.
- R2: Channel n's priority byte is byte (n mod 4), bits [8k+7:8k] with k = n mod 4, of register word n/4. Words 0 to NUM_CH/4-1 hold these bytes.
- R3: After reset, all priorities, the enable word, the grouping field and both mask bits are zero, nothing is pending, and `take_req` is low.
- R4: The control word is at address NUM_CH/4. Its bits [2:0] hold the grouping field g. A write of a value above 4 leaves g unchanged. The top g priority bits form the preemption level and the remaining bits form the sub-priority.
- R5: The enable word is at address NUM_CH/4+1, with bit n for channel n. Among enabled pending channels, the winner has the numerically lowest priority value, and a tie goes to the lowest index. A disabled channel stays pending but is never offered.
- R6: A channel is offered only when its preemption level is strictly lower than the preemption level of the running handler. An equal level waits until that handler ends.
- R7: With g = 4, sixteen programmable handlers can nest. Each end-of-handler pulse restores the previous execution priority, so a request that was blocked by the popped handler is offered next.
- R8: Control bit 8 is the global mask. It raises the execution priority to the most urgent programmable level, so no channel is offered, while hard-fault and non-maskable requests are still offered.
- R9: Control bit 9 is the fault mask. It blocks the hard fault too, so only the non-maskable request is offered. The bit clears itself on every end-of-handler pulse.
- R10: Source order is non-maskable, then hard fault, then channels. `take_id` is the channel index, NUM_CH for the hard fault, or NUM_CH+1 for the non-maskable request.
- R11: When `take_req` and `take_ack` are high in the same cycle, the offered source's pending flag clears and its level is pushed. That source is not offered again until it requests again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_i | input | NUM_CH | Per-channel request pulses |
| nmi_i | input | 1 | Non-maskable request pulse |
| fault_i | input | 1 | Hard-fault request pulse |
| hdl_done | input | 1 | End-of-handler pulse |
| take_req | output | 1 | A source is offered to the core |
| take_id | output | ID_W | Identifier of the offered source |
| take_ack | input | 1 | Core accepts the offered source |

## Verification
The bench uses the default parameters: NUM_CH = 16 and 4 priority bits. With these values the full 16-deep programmable nesting chain can be exercised, including a retake after one level is popped. Sixteen channels fill exactly four packed priority words, so the byte placement of every word can be checked. The 4-bit priorities allow the grouping field to be tested at its extremes (0 and 4) and at a mid split (2). At the mid split, two requests can share a preemption level and differ only in sub-priority.

// File: rtl/irq_nest_pkg.sv
`timescale 1ns/1ps
package irq_nest_pkg;
  // execution-level encoding: smaller is more urgent
  localparam int unsigned LVL_NMI   = 0;
  localparam int unsigned LVL_FAULT = 1;
  localparam int unsigned LVL_CH0   = 2;
  // control word fields
  localparam int unsigned CTL_GMASK = 8;
  localparam int unsigned CTL_FMASK = 9;
endpackage

// File: rtl/irq_prio_regs.sv
`timescale 1ns/1ps
module irq_prio_regs #(
  parameter int NUM_CH    = 16,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic                 hdl_done,
  output logic [PRIO_BITS-1:0] prio_o [NUM_CH],
  output logic [NUM_CH-1:0]    en_o,
  output logic [2:0]           grp_o,
  output logic                 gmask_o,
  output logic                 fmask_o
);
  import irq_nest_pkg::*;
  localparam int PRI_WORDS = (NUM_CH + 3) / 4;
  localparam int CTRL_ADR  = PRI_WORDS;
  localparam int EN_ADR    = PRI_WORDS + 1;

  logic [PRIO_BITS-1:0] prio_q [NUM_CH];
  logic [PRIO_BITS-1:0] prio_d [NUM_CH];
  logic [NUM_CH-1:0]    en_q, en_d;
  logic [2:0]           grp_q, grp_d;
  logic                 gm_q, gm_d, fm_q, fm_d;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      prio_d[i] = prio_q[i];
      if (wr_en && addr == ADDR_W'(i / 4))
        prio_d[i] = wdata[8*(i%4)+7 -: PRIO_BITS];
    end
    en_d  = en_q;
    grp_d = grp_q;
    gm_d  = gm_q;
    fm_d  = fm_q;
    if (wr_en && addr == ADDR_W'(EN_ADR)) en_d = wdata[NUM_CH-1:0];
    if (wr_en && addr == ADDR_W'(CTRL_ADR)) begin
      if (wdata[2:0] <= 3'(PRIO_BITS)) grp_d = wdata[2:0];
      gm_d = wdata[CTL_GMASK];
      fm_d = wdata[CTL_FMASK];
    end
    if (hdl_done) fm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) prio_q[i] <= '0;
      en_q  <= '0;
      grp_q <= '0;
      gm_q  <= 1'b0;
      fm_q  <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) prio_q[i] <= prio_d[i];
      en_q  <= en_d;
      grp_q <= grp_d;
      gm_q  <= gm_d;
      fm_q  <= fm_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(i / 4)) rdata[8*(i%4)+7 -: PRIO_BITS] = prio_q[i];
    if (addr == ADDR_W'(CTRL_ADR)) begin
      rdata[2:0]       = grp_q;
      rdata[CTL_GMASK] = gm_q;
      rdata[CTL_FMASK] = fm_q;
    end
    if (addr == ADDR_W'(EN_ADR)) rdata[NUM_CH-1:0] = en_q;
  end

  assign prio_o  = prio_q;
  assign en_o    = en_q;
  assign grp_o   = grp_q;
  assign gmask_o = gm_q;
  assign fmask_o = fm_q;
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
  parameter int NUM_CH    = 16,
  parameter int PRIO_BITS = 4,
  parameter int IDX_W     = 4
) (
  input  logic [NUM_CH-1:0]    cand,
  input  logic [PRIO_BITS-1:0] prio [NUM_CH],
  output logic                 found,
  output logic [IDX_W-1:0]     idx,
  output logic [PRIO_BITS-1:0] best
);
  // whole-value compare orders by preemption first, then sub-priority;
  // strict less keeps the lowest index on a tie
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cand[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_active_stack.sv
`timescale 1ns/1ps
module irq_active_stack #(
  parameter int LVL_W = 6,
  parameter int DEPTH = 18,
  parameter int DW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] top_lvl,
  output logic [DW-1:0]    depth
);
  logic [LVL_W-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] stk_d [DEPTH];
  logic [DW-1:0]    sp_q, sp_d;

  always_comb begin
    stk_d = stk_q;
    sp_d  = sp_q;
    if (pop && sp_q != '0) begin
      sp_d = sp_q - DW'(1);
    end else if (push && sp_q < DW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (sp_q == DW'(i)) stk_d[i] = push_lvl;
      sp_d = sp_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
      sp_q <= '0;
    end else begin
      stk_q <= stk_d;
      sp_q  <= sp_d;
    end
  end

  always_comb begin
    top_lvl = '1;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == DW'(i + 1)) top_lvl = stk_q[i];
  end

  assign depth = sp_q;
endmodule

// File: rtl/irq_nest_arb.sv
`timescale 1ns/1ps
module irq_nest_arb #(
  parameter int NUM_CH    = 16,
  parameter int PRIO_BITS = 4,
  parameter int ADDR_W    = 3,
  parameter int ID_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] irq_i,
  input  logic              nmi_i,
  input  logic              fault_i,
  input  logic              hdl_done,
  output logic              take_req,
  output logic [ID_W-1:0]   take_id,
  input  logic              take_ack
);
  import irq_nest_pkg::*;
  localparam int LVL_W = PRIO_BITS + 2;
  localparam int DEPTH = (1 << PRIO_BITS) + 2;
  localparam int DW    = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(NUM_CH);

  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic [PRIO_BITS-1:0] prio [NUM_CH];
  logic [NUM_CH-1:0]    en, pend_q, pend_d, clr_vec;
  logic [2:0]           grp;
  logic                 gmask, fmask, nmi_q, nmi_d, flt_q, flt_d;
  logic                 found, accept, sel_req, sel_ch;
  logic [IDX_W-1:0]     widx;
  logic [PRIO_BITS-1:0] wprio, wpre;
  logic [LVL_W-1:0]     ch_lvl, top_lvl, ex_lvl, sel_lvl;
  logic [ID_W-1:0]      sel_id;
  logic [DW-1:0]        depth;

  irq_prio_regs #(.NUM_CH(NUM_CH), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .hdl_done(hdl_done),
    .prio_o(prio), .en_o(en), .grp_o(grp), .gmask_o(gmask), .fmask_o(fmask));

  irq_pick #(.NUM_CH(NUM_CH), .PRIO_BITS(PRIO_BITS), .IDX_W(IDX_W)) u_pick (
    .cand(pend_q & en), .prio(prio), .found(found), .idx(widx), .best(wprio));

  irq_active_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH), .DW(DW)) u_stack (
    .clk(clk), .rst_n(rst_core_n), .push(accept), .push_lvl(sel_lvl),
    .pop(hdl_done), .top_lvl(top_lvl), .depth(depth));

  // preemption level = top g bits of the winner's priority
  assign wpre   = wprio >> (3'(PRIO_BITS) - grp);
  assign ch_lvl = LVL_W'(wpre) + LVL_W'(LVL_CH0);

  always_comb begin
    ex_lvl = top_lvl;
    if (gmask && ex_lvl > LVL_W'(LVL_CH0))   ex_lvl = LVL_W'(LVL_CH0);
    if (fmask && ex_lvl > LVL_W'(LVL_FAULT)) ex_lvl = LVL_W'(LVL_FAULT);
  end

  always_comb begin
    sel_req = 1'b0;
    sel_ch  = 1'b0;
    sel_id  = '0;
    sel_lvl = '0;
    if (nmi_q && ex_lvl > LVL_W'(LVL_NMI)) begin
      sel_req = 1'b1;
      sel_id  = ID_W'(NUM_CH + 1);
      sel_lvl = LVL_W'(LVL_NMI);
    end else if (flt_q && ex_lvl > LVL_W'(LVL_FAULT)) begin
      sel_req = 1'b1;
      sel_id  = ID_W'(NUM_CH);
      sel_lvl = LVL_W'(LVL_FAULT);
    end else if (found && ch_lvl < ex_lvl) begin
      sel_req = 1'b1;
      sel_ch  = 1'b1;
      sel_id  = ID_W'(widx);
      sel_lvl = ch_lvl;
    end
  end

  assign take_req = sel_req & ~hdl_done;
  assign take_id  = sel_id;
  assign accept   = take_req & take_ack;

  always_comb begin
    clr_vec = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (accept && sel_ch && widx == IDX_W'(i)) clr_vec[i] = 1'b1;
    pend_d = (pend_q & ~clr_vec) | irq_i;
    nmi_d  = (nmi_q & ~(accept && sel_id == ID_W'(NUM_CH + 1))) | nmi_i;
    flt_d  = (flt_q & ~(accept && sel_id == ID_W'(NUM_CH))) | fault_i;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pend_q <= '0;
      nmi_q  <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      nmi_q  <= nmi_d;
      flt_q  <= flt_d;
    end
  end
endmodule

// File: rtl/irq_nest_arb_sva.sv
`timescale 1ns/1ps
module irq_nest_arb_sva #(
  parameter int NUM_CH = 16,
  parameter int ID_W   = 5,
  parameter int DW     = 5,
  parameter int DEPTH  = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_req,
  input logic            take_ack,
  input logic [ID_W-1:0] take_id,
  input logic            hdl_done,
  input logic [DW-1:0]   depth,
  input logic            gmask,
  input logic            fmask
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH)); // R7
  AST_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (hdl_done && depth != '0) |=> depth == $past(depth) - DW'(1)); // R7
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && take_ack) |=> depth == $past(depth) + DW'(1)); // R11
  AST_GMASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && take_req) |-> take_id >= ID_W'(NUM_CH)); // R8
  AST_FMASK_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (fmask && take_req) |-> take_id == ID_W'(NUM_CH + 1)); // R9
  AST_FMASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_done |=> !fmask); // R9
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> take_id <= ID_W'(NUM_CH + 1)); // R10
endmodule

bind irq_nest_arb irq_nest_arb_sva #(
  .NUM_CH(NUM_CH), .ID_W(ID_W), .DW(DW), .DEPTH(DEPTH)
) u_sva (
  .clk(clk), .rst_n(rst_core_n), .take_req(take_req), .take_ack(take_ack),
  .take_id(take_id), .hdl_done(hdl_done), .depth(depth),
  .gmask(gmask), .fmask(fmask)
);

// File: tb/irq_nest_arb_test.sv
`timescale 1ns/1ps
module irq_nest_arb_test;
  localparam int NUM_CH = 16;
  localparam int ADDR_W = 3;
  localparam int ID_W   = 5;
  localparam int A_CTRL = 4;
  localparam int A_EN   = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NUM_CH-1:0] irq_i = '0;
  logic              nmi_i = 1'b0;
  logic              fault_i = 1'b0;
  logic              hdl_done = 1'b0;
  logic              take_req;
  logic [ID_W-1:0]   take_id;
  logic              take_ack = 1'b0;

  int    n_chk = 0, n_bad = 0, taken_cnt = 0, tk = 0;
  int    exp_id[$];
  string exp_rq[$];
  logic [3:0] sh [NUM_CH];

  always #2.5 clk = ~clk;

  irq_nest_arb #(.NUM_CH(NUM_CH), .PRIO_BITS(4), .ADDR_W(ADDR_W), .ID_W(ID_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_i(irq_i), .nmi_i(nmi_i),
    .fault_i(fault_i), .hdl_done(hdl_done), .take_req(take_req),
    .take_id(take_id), .take_ack(take_ack));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every offered source and accepts it
  initial begin : monitor
    forever begin
      @(negedge clk);
      take_ack = 1'b0;
      if (rst_n && take_req === 1'b1) begin
        if (exp_id.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R11 unexpected take actual=%0d expected=none", take_id);
        end else begin
          int    e;
          string r;
          e = exp_id.pop_front();
          r = exp_rq.pop_front();
          check(r, 32'(take_id), 32'(e));
        end
        take_ack = 1'b1;
        taken_cnt++;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic expect_take(input int id, input string rq);
    exp_id.push_back(id);
    exp_rq.push_back(rq);
    tk++;
  endtask

  task automatic wait_taken();
    while (taken_cnt < tk) @(posedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string rq);
    @(posedge clk); #1;
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    check(rq, reg_rdata, exp);
  endtask

  task automatic put_word(input int w);
    logic [31:0] d;
    d = '0;
    for (int b = 0; b < 4; b++) d[8*b+4 +: 4] = sh[4*w+b];
    wr(w, d);
  endtask

  task automatic set_prio(input int ch, input logic [3:0] v);
    sh[ch] = v;
    put_word(ch / 4);
  endtask

  task automatic pulse(input logic [NUM_CH-1:0] m, input logic n, input logic f);
    @(posedge clk); #1;
    irq_i = m; nmi_i = n; fault_i = f;
    @(posedge clk); #1;
    irq_i = '0; nmi_i = 1'b0; fault_i = 1'b0;
  endtask

  task automatic done();
    @(posedge clk); #1;
    hdl_done = 1'b1;
    @(posedge clk); #1;
    hdl_done = 1'b0;
  endtask

  task automatic idle_chk(input string rq);
    repeat (2) begin
      @(negedge clk);
      check(rq, 32'(take_req), 32'd0);
    end
  endtask

  initial begin : driver
    for (int i = 0; i < NUM_CH; i++) sh[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R3 reset state
    for (int w = 0; w < 4; w++) rd_chk(w, 32'h0, "R3 prio word");
    rd_chk(A_CTRL, 32'h0, "R3 ctrl");
    rd_chk(A_EN, 32'h0, "R3 enable");
    @(negedge clk);
    check("R3 take_req", 32'(take_req), 32'd0);

    // R1 R2 byte packing and low-nibble discard
    wr(1, 32'h1234A75F);
    rd_chk(1, 32'h1030A050, "R1 R2 packed word");
    rd_chk(0, 32'h0, "R2 neighbour word");
    wr(1, 32'h0);
    wr(A_EN, 32'h0000FFFF);
    rd_chk(A_EN, 32'h0000FFFF, "R5 enable readback");

    // group 0: tie-break by sub-priority then index, no preemption
    set_prio(3, 4'h2); set_prio(7, 4'h1); set_prio(9, 4'h1);
    expect_take(7, "R5 best prio");
    expect_take(9, "R5 index tie");
    expect_take(3, "R5 last");
    pulse(16'h0288, 1'b0, 1'b0);
    tk = tk - 2; wait_taken();
    idle_chk("R6 group0 no preempt");
    tk++; done(); wait_taken();
    tk++; done(); wait_taken();
    done();
    idle_chk("R11 no retake");

    // R4 grouping field write rules
    wr(A_CTRL, 32'h2);
    rd_chk(A_CTRL, 32'h2, "R4 group set");
    wr(A_CTRL, 32'h7);
    rd_chk(A_CTRL, 32'h2, "R4 group >4 ignored");

    // group 2: preemption vs sub-priority
    set_prio(2, 4'h5); set_prio(4, 4'h4); set_prio(6, 4'h3);
    expect_take(2, "R4 first");
    pulse(16'h0004, 1'b0, 1'b0); wait_taken();
    pulse(16'h0010, 1'b0, 1'b0);
    idle_chk("R6 equal preempt waits");
    expect_take(6, "R4 upper bits preempt");
    pulse(16'h0040, 1'b0, 1'b0); wait_taken();
    done();
    idle_chk("R6 sub-priority never preempts");
    expect_take(4, "R6 after return");
    done(); wait_taken();
    done(); done();
    idle_chk("R11 stack empty");

    // group 4: sixteen nested levels
    wr(A_CTRL, 32'h4);
    for (int i = 0; i < NUM_CH; i++) sh[i] = 4'(15 - i);
    for (int w = 0; w < 4; w++) put_word(w);
    for (int i = 0; i < NUM_CH; i++) begin
      expect_take(i, "R7 nest");
      pulse(NUM_CH'(1) << i, 1'b0, 1'b0);
      wait_taken();
    end
    pulse(16'h8000, 1'b0, 1'b0);
    idle_chk("R6 deepest equal blocked");
    expect_take(15, "R7 restore after pop");
    done(); wait_taken();
    for (int i = 0; i < NUM_CH; i++) done();
    idle_chk("R7 all popped");

    // R5 disabled channel stays pending
    wr(A_EN, 32'h0000FEFF);
    pulse(16'h0100, 1'b0, 1'b0);
    idle_chk("R5 disabled not offered");
    expect_take(8, "R5 pending kept");
    wr(A_EN, 32'h0000FFFF);
    wait_taken(); done();

    // R8 global mask
    wr(A_CTRL, 32'h104);
    pulse(16'h0002, 1'b0, 1'b0);
    idle_chk("R8 channel masked");
    expect_take(NUM_CH, "R8 fault passes");
    pulse('0, 1'b0, 1'b1); wait_taken();
    done();
    idle_chk("R8 still masked");
    expect_take(1, "R8 unmask");
    wr(A_CTRL, 32'h4);
    wait_taken(); done();

    // R9 fault mask
    wr(A_CTRL, 32'h204);
    pulse('0, 1'b0, 1'b1);
    idle_chk("R9 fault masked");
    expect_take(NUM_CH + 1, "R9 nmi passes");
    pulse('0, 1'b1, 1'b0); wait_taken();
    rd_chk(A_CTRL, 32'h204, "R9 bit held");
    expect_take(NUM_CH, "R9 fault after auto-clear");
    done(); wait_taken();
    rd_chk(A_CTRL, 32'h4, "R9 bit cleared");
    done();

    // R10 source order
    expect_take(NUM_CH + 1, "R10 nmi first");
    expect_take(NUM_CH, "R10 fault second");
    expect_take(0, "R10 channel last");
    tk = tk - 2;
    pulse(16'h0001, 1'b1, 1'b1); wait_taken();
    idle_chk("R10 nmi blocks all");
    tk++; done(); wait_taken();
    tk++; done(); wait_taken();
    done();
    idle_chk("R11 all cleared");

    repeat (4) @(posedge clk);
    if (exp_id.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R11 missing takes actual=%0d expected=0", exp_id.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule